// File: doc/BRIEF.md
# Transfer-Length and DMA Completion Controller

This block decides how many bytes a transfer-information step moves. It then follows that transfer one chunk at a time until it is complete. Software programs a 16-bit byte count as two bytes. A separate signed residual describes the data phase that is still open: a positive value means bytes flow from the device toward the host, and a negative value means bytes flow toward the device. In the command phase the length is capped at a small fixed limit. In the data phase the length is capped at the magnitude of the residual.

When a transfer is started, the block loads a remaining-byte counter. The device side announces how many bytes its buffer holds through an offer pulse. The block then raises a request for the next chunk, and the memory side answers with an acknowledge that carries the byte count it actually moved. Every acknowledged chunk lowers the remaining counter and moves the residual toward zero.

The block decides when the transfer is finished. Some conditions finish it at once, and others defer completion until the device offers its next buffer. On completion it loads the status byte, the interrupt code and the count bytes with their completion values, and it raises the interrupt.

Top module: `dma_len_ctl`

## Requirements
- R1: The programmed length is `cnt_lo_i + 256*cnt_mid_i`, sampled on `start_i`; a programmed value of zero stands for 65536 bytes.
- R2: With `cmd_phase_i` set at start, `remain_o` becomes min(programmed, 32). The request is raised at once for the whole remaining count. An acknowledge that brings the counter to zero pulses `cmd_done_o` for one cycle and clears `active_o`, without a completion.
- R3: With `cmd_phase_i` clear, `remain_o` becomes min(programmed, |`residual_i`|). A negative residual marks a transfer toward the device.
- R4: One cycle after `start_i`, `remain_o`, `residual_o`, `cnt_lo_o` and `cnt_mid_o` hold the new values, status bit 4 (terminal count) is clear, and the buffered offer is discarded. A start during an active transfer replaces it.
- R5: An acknowledged chunk length is clipped to `req_len_o`, so it never exceeds `remain_o`. It is subtracted from `remain_o`, and `residual_o` moves toward zero by the same amount (up when negative, down when positive).
- R6: A completion takes effect one cycle after its cause. `done_o` pulses. `stat_o` gets bit 4 (terminal count) and bit 7 (interrupt), so it reads 0x90. `intr_o` becomes 0x10, `cnt_lo_o` and `cnt_mid_o` become 0, and `active_o` clears.
- R7: If device-buffer bytes remain unused after an acknowledged data chunk, completion happens immediately.
- R8: For a transfer from the device, completion also happens when a chunk takes `remain_o` to zero while the residual is still above zero.
- R9: An offer that arrives while `remain_o` is zero, a data transfer was started and has not yet completed, and the residual is zero or below, causes completion. Offers that arrive after that completion cause nothing.
- R10: `intr_ack_i` clears `intr_o` and status bit 7 but leaves status bit 4 unchanged.
- R11: `req_o` is high only while active with a nonzero `remain_o` and, in the data phase, a nonzero offered byte count. `req_len_o` is `remain_o` in the command phase and min(`remain_o`, offered bytes) in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer step |
| cmd_phase_i | input | 1 | Transfer belongs to the command phase |
| cnt_lo_i | input | 8 | Programmed count, low byte |
| cnt_mid_i | input | 8 | Programmed count, high byte |
| residual_i | input | 24 | Signed data-phase residual |
| offer_i | input | 1 | Device buffer announces bytes |
| offer_len_i | input | 17 | Bytes held by the device buffer |
| req_o | output | 1 | Chunk request to memory side |
| req_len_o | output | 17 | Bytes requested |
| ack_i | input | 1 | Chunk acknowledge |
| ack_len_i | input | 17 | Bytes actually moved |
| intr_ack_i | input | 1 | Interrupt acknowledge |
| remain_o | output | 17 | Remaining-byte counter |
| residual_o | output | 24 | Current signed residual |
| active_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| cmd_done_o | output | 1 | One-cycle command-fetch strobe |
| stat_o | output | 8 | Status byte (bit 4 terminal count, bit 7 interrupt) |
| intr_o | output | 8 | Interrupt code |
| cnt_lo_o | output | 8 | Count register, low byte |
| cnt_mid_o | output | 8 | Count register, high byte |

## Verification
The deferred completion is the hardest case to reach. It needs a chunk that uses the device buffer exactly, so that no leftover bytes trigger the immediate path. That chunk must also leave the counter at zero with a residual at or below zero. Only then does a second offer finish the transfer. The stimulus sets up this state in three ways: a write transfer split into two exact chunks, a read transfer whose residual is smaller than the programmed count, and an oversized acknowledge that clipping brings back to the exact size. A further offer after each completion must then produce no strobe at all.

// File: rtl/dma_len_pkg.sv
package dma_len_pkg;
    localparam int          STAT_TC_BIT   = 4;
    localparam int          STAT_INT_BIT  = 7;
    localparam logic [7:0]  INTR_SVC_CODE = 8'h10;
endpackage

// File: rtl/dlc_min.sv
module dlc_min #(
    parameter int W = 17
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    assign y_o = (a_i < b_i) ? a_i : b_i;
endmodule

// File: rtl/dlc_len_calc.sv
module dlc_len_calc #(
    parameter int CNT_W     = 16,
    parameter int RES_W     = 24,
    parameter int CMD_LIMIT = 32
) (
    input  logic [CNT_W/2-1:0]     lo_i,
    input  logic [CNT_W/2-1:0]     mid_i,
    input  logic                   cmd_i,
    input  logic signed [RES_W-1:0] residual_i,
    output logic [CNT_W:0]         len_o
);
    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] prog;
    logic [LEN_W-1:0] prog_len;
    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] bound;
    logic [RES_W-1:0] wide_len;

    assign prog     = {mid_i, lo_i};
    // a zero count stands for the full 2^CNT_W range
    assign prog_len = (prog == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, prog};
    assign mag      = residual_i[RES_W-1] ? $unsigned(-residual_i) : $unsigned(residual_i);
    assign bound    = cmd_i ? RES_W'(CMD_LIMIT) : mag;

    dlc_min #(.W(RES_W)) u_len_min (
        .a_i (RES_W'(prog_len)),
        .b_i (bound),
        .y_o (wide_len)
    );

    assign len_o = wide_len[LEN_W-1:0];
endmodule

// File: rtl/dma_len_ctl.sv
module dma_len_ctl
    import dma_len_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RES_W     = 24,
    parameter int CMD_LIMIT = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       cmd_phase_i,
    input  logic [CNT_W/2-1:0]         cnt_lo_i,
    input  logic [CNT_W/2-1:0]         cnt_mid_i,
    input  logic signed [RES_W-1:0]    residual_i,
    input  logic                       offer_i,
    input  logic [CNT_W:0]             offer_len_i,
    output logic                       req_o,
    output logic [CNT_W:0]             req_len_o,
    input  logic                       ack_i,
    input  logic [CNT_W:0]             ack_len_i,
    input  logic                       intr_ack_i,
    output logic [CNT_W:0]             remain_o,
    output logic signed [RES_W-1:0]    residual_o,
    output logic                       active_o,
    output logic                       done_o,
    output logic                       cmd_done_o,
    output logic [7:0]                 stat_o,
    output logic [7:0]                 intr_o,
    output logic [CNT_W/2-1:0]         cnt_lo_o,
    output logic [CNT_W/2-1:0]         cnt_mid_o
);
    localparam int LEN_W  = CNT_W + 1;
    localparam int BYTE_W = CNT_W / 2;

    typedef struct packed {
        logic [LEN_W-1:0]        remain;
        logic signed [RES_W-1:0] residual;
        logic [LEN_W-1:0]        avail;
        logic                    active;
        logic                    started;
        logic                    cmd;
        logic                    tc;
        logic                    irq;
        logic [7:0]              intr;
        logic [BYTE_W-1:0]       cnt_lo;
        logic [BYTE_W-1:0]       cnt_mid;
        logic                    done;
        logic                    cmd_done;
    } ctl_st_t;

    ctl_st_t s_q, s_d;

    logic [LEN_W-1:0]        start_len;
    logic [LEN_W-1:0]        data_req_len;
    logic [LEN_W-1:0]        take;
    logic signed [RES_W-1:0] step;

    dlc_len_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .CMD_LIMIT(CMD_LIMIT)) u_len (
        .lo_i       (cnt_lo_i),
        .mid_i      (cnt_mid_i),
        .cmd_i      (cmd_phase_i),
        .residual_i (residual_i),
        .len_o      (start_len)
    );

    dlc_min #(.W(LEN_W)) u_req_min (
        .a_i (s_q.remain),
        .b_i (s_q.avail),
        .y_o (data_req_len)
    );

    assign req_len_o = s_q.cmd ? s_q.remain : data_req_len;
    assign req_o     = s_q.active && (s_q.remain != '0) && (s_q.cmd || (s_q.avail != '0));

    dlc_min #(.W(LEN_W)) u_ack_clip (
        .a_i (ack_len_i),
        .b_i (req_len_o),
        .y_o (take)
    );

    assign step = $signed(RES_W'(take));

    always_comb begin
        logic                    fin;
        logic                    to_dev;
        logic [LEN_W-1:0]        remain_nx;
        logic [LEN_W-1:0]        avail_nx;
        logic signed [RES_W-1:0] res_nx;

        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.cmd_done = 1'b0;
        fin         = 1'b0;
        to_dev      = (s_q.residual < 0);
        remain_nx   = s_q.remain - take;
        avail_nx    = s_q.avail - take;
        res_nx      = to_dev ? (s_q.residual + step) : (s_q.residual - step);

        if (intr_ack_i) begin
            s_d.irq  = 1'b0;
            s_d.intr = '0;
        end

        if (ack_i && req_o) begin
            s_d.remain = remain_nx;
            if (s_q.cmd) begin
                if (remain_nx == '0) begin
                    s_d.active   = 1'b0;
                    s_d.cmd_done = 1'b1;
                end
            end else begin
                s_d.avail    = avail_nx;
                s_d.residual = res_nx;
                if (avail_nx != '0) begin
                    fin = 1'b1;
                end else if (!to_dev && (remain_nx == '0) && (res_nx > 0)) begin
                    fin = 1'b1;
                end
            end
        end else if (offer_i && !s_q.cmd) begin
            s_d.avail = offer_len_i;
            if ((s_q.remain == '0) && s_q.started && (s_q.residual <= 0)) begin
                fin = 1'b1;
            end
        end

        if (start_i) begin
            s_d.remain   = start_len;
            s_d.residual = residual_i;
            s_d.avail    = '0;
            s_d.active   = 1'b1;
            s_d.started  = !cmd_phase_i;
            s_d.cmd      = cmd_phase_i;
            s_d.tc       = 1'b0;
            s_d.cnt_lo   = cnt_lo_i;
            s_d.cnt_mid  = cnt_mid_i;
            s_d.done     = 1'b0;
            s_d.cmd_done = 1'b0;
        end else if (fin) begin
            s_d.done    = 1'b1;
            s_d.tc      = 1'b1;
            s_d.irq     = 1'b1;
            s_d.intr    = INTR_SVC_CODE;
            s_d.cnt_lo  = '0;
            s_d.cnt_mid = '0;
            s_d.active  = 1'b0;
            s_d.started = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        stat_o               = '0;
        stat_o[STAT_TC_BIT]  = s_q.tc;
        stat_o[STAT_INT_BIT] = s_q.irq;
    end

    assign remain_o   = s_q.remain;
    assign residual_o = s_q.residual;
    assign active_o   = s_q.active;
    assign done_o     = s_q.done;
    assign cmd_done_o = s_q.cmd_done;
    assign intr_o     = s_q.intr;
    assign cnt_lo_o   = s_q.cnt_lo;
    assign cnt_mid_o  = s_q.cnt_mid;

    // R6
    done_loads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stat_o[STAT_TC_BIT] && stat_o[STAT_INT_BIT] && intr_o == INTR_SVC_CODE
                    && cnt_lo_o == '0 && cnt_mid_o == '0 && !active_o));

    // R4
    start_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!stat_o[STAT_TC_BIT] && active_o && remain_o <= (LEN_W'(1) << CNT_W)));

    // R5
    ack_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_o && !start_i) |=> (remain_o <= $past(remain_o)));

    // R11
    req_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_len_o != '0 && req_len_o <= remain_o));

    // R2
    cmd_fetch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |-> (remain_o == '0 && !active_o && !done_o));

    // R10
    intr_ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_ack_i && !ack_i && !offer_i) |=> !stat_o[STAT_INT_BIT]);
endmodule

// File: tb/test_dma_len_ctl.sv
module test_dma_len_ctl;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0, cmd_phase_i = 1'b0;
    logic [7:0]         cnt_lo_i = '0, cnt_mid_i = '0;
    logic signed [23:0] residual_i = '0;
    logic               offer_i = 1'b0;
    logic [16:0]        offer_len_i = '0;
    logic               req_o;
    logic [16:0]        req_len_o;
    logic               ack_i = 1'b0;
    logic [16:0]        ack_len_i = '0;
    logic               intr_ack_i = 1'b0;
    logic [16:0]        remain_o;
    logic signed [23:0] residual_o;
    logic               active_o, done_o, cmd_done_o;
    logic [7:0]         stat_o, intr_o, cnt_lo_o, cnt_mid_o;

    int checks = 0;
    int failures = 0;
    int scen = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_len_ctl i_dma_len_ctl (
        .clk, .rst_n, .start_i, .cmd_phase_i, .cnt_lo_i, .cnt_mid_i, .residual_i,
        .offer_i, .offer_len_i, .req_o, .req_len_o, .ack_i, .ack_len_i, .intr_ack_i,
        .remain_o, .residual_o, .active_o, .done_o, .cmd_done_o, .stat_o, .intr_o,
        .cnt_lo_o, .cnt_mid_o
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s scen=%0d got=%0d exp=%0d", tag, scen, got, exp);
        end
    endtask

    // monitor: every completion strobe must match a queued expectation
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R6 unexpected done scen=%0d got=1 exp=0", scen);
            end else begin
                int id;
                id = exp_q.pop_front();
                if (id != scen) begin
                    failures++;
                    $display("FAIL R6 done tag got=%0d exp=%0d", scen, id);
                end
            end
        end
    end

    task automatic expect_done();
        exp_q.push_back(scen);
    endtask

    task automatic drain(string tag);
        repeat (2) @(negedge clk);
        chk(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic do_start(bit cmd, int lo, int mid, int res);
        @(negedge clk);
        start_i = 1'b1; cmd_phase_i = cmd;
        cnt_lo_i = 8'(lo); cnt_mid_i = 8'(mid); residual_i = 24'(res);
        @(negedge clk);
        start_i = 1'b0; cmd_phase_i = 1'b0;
    endtask

    task automatic do_offer(int n);
        @(negedge clk);
        offer_i = 1'b1; offer_len_i = 17'(n);
        @(negedge clk);
        offer_i = 1'b0;
    endtask

    task automatic do_ack(int n);
        @(negedge clk);
        ack_i = 1'b1; ack_len_i = 17'(n);
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic do_iack();
        @(negedge clk);
        intr_ack_i = 1'b1;
        @(negedge clk);
        intr_ack_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        scen = 1;
        chk("R6 reset remain", int'(remain_o), 0);
        chk("R6 reset stat", int'(stat_o), 0);
        chk("R6 reset intr", int'(intr_o), 0);
        chk("R11 reset req", int'(req_o), 0);
        chk("R4 reset active", int'(active_o), 0);

        scen = 2;
        do_start(1'b0, 0, 0, 70000);
        chk("R1 zero count", int'(remain_o), 65536);
        do_start(1'b0, 5, 1, 300);
        chk("R1 two bytes", int'(remain_o), 261);
        chk("R4 cnt_lo", int'(cnt_lo_o), 5);
        chk("R4 cnt_mid", int'(cnt_mid_o), 1);
        do_start(1'b0, 100, 0, -20);
        chk("R3 negative residual clip", int'(remain_o), 20);
        chk("R4 residual loaded", int'(residual_o), -20);
        chk("R11 no offer no req", int'(req_o), 0);

        scen = 3;
        do_start(1'b1, 200, 0, 0);
        chk("R2 cmd cap", int'(remain_o), 32);
        chk("R2 cmd req", int'(req_o), 1);
        chk("R11 cmd req_len", int'(req_len_o), 32);
        do_start(1'b1, 5, 0, 0);
        do_ack(5);
        chk("R2 cmd_done pulse", int'(cmd_done_o), 1);
        chk("R2 cmd remain", int'(remain_o), 0);
        @(negedge clk);
        chk("R2 cmd_done one cycle", int'(cmd_done_o), 0);
        drain("R2 no completion");

        scen = 4;
        do_start(1'b0, 4, 0, 8);
        do_offer(8);
        chk("R11 req after offer", int'(req_o), 1);
        chk("R11 req_len min", int'(req_len_o), 4);
        expect_done();
        do_ack(4);
        chk("R7 stat", int'(stat_o), 8'h90);
        chk("R6 intr", int'(intr_o), 8'h10);
        chk("R6 cnt_lo zero", int'(cnt_lo_o), 0);
        chk("R5 residual down", int'(residual_o), 4);
        chk("R6 inactive", int'(active_o), 0);
        drain("R7 one strobe");

        scen = 5;
        do_iack();
        chk("R10 stat keeps tc", int'(stat_o), 8'h10);
        chk("R10 intr cleared", int'(intr_o), 0);
        do_start(1'b0, 4, 0, 8);
        chk("R4 tc cleared", int'(stat_o), 0);

        scen = 6;
        do_offer(4);
        expect_done();
        do_ack(4);
        chk("R8 read exhaust stat", int'(stat_o), 8'h90);
        chk("R8 residual left", int'(residual_o), 4);
        drain("R8 strobe");

        scen = 7;
        do_iack();
        do_start(1'b0, 8, 0, 8);
        do_offer(8);
        expect_done();
        do_ack(3);
        chk("R7 short ack remain", int'(remain_o), 5);
        chk("R7 short ack residual", int'(residual_o), 5);
        chk("R7 short ack stat", int'(stat_o), 8'h90);
        drain("R7 short strobe");

        scen = 8;
        do_iack();
        do_start(1'b0, 8, 0, 4);
        chk("R3 residual caps", int'(remain_o), 4);
        do_offer(4);
        do_ack(4);
        chk("R9 no early done stat", int'(stat_o), 0);
        chk("R5 residual zero", int'(residual_o), 0);
        drain("R9 no early strobe");
        expect_done();
        do_offer(2);
        chk("R9 deferred read stat", int'(stat_o), 8'h90);
        drain("R9 deferred read strobe");
        do_iack();
        do_offer(2);
        chk("R9 later offer no irq", int'(stat_o), 8'h10);
        drain("R9 later offer no strobe");

        scen = 9;
        do_start(1'b0, 4, 0, -4);
        do_offer(4);
        do_ack(4);
        chk("R5 write residual up", int'(residual_o), 0);
        drain("R9 write wait");
        expect_done();
        do_offer(1);
        chk("R9 deferred write stat", int'(stat_o), 8'h90);
        drain("R9 write strobe");

        scen = 10;
        do_iack();
        do_start(1'b0, 6, 0, -6);
        do_offer(3);
        do_ack(3);
        chk("R5 chunk remain", int'(remain_o), 3);
        chk("R5 chunk residual", int'(residual_o), -3);
        chk("R5 still active", int'(active_o), 1);
        do_offer(3);
        do_ack(3);
        chk("R5 second chunk", int'(remain_o), 0);
        drain("R9 multi wait");
        expect_done();
        do_offer(3);
        drain("R9 multi strobe");

        scen = 11;
        do_iack();
        do_start(1'b0, 8, 0, 8);
        do_offer(8);
        do_ack(20);
        chk("R5 clip remain", int'(remain_o), 0);
        chk("R5 clip residual", int'(residual_o), 0);
        drain("R5 clip no strobe");
        expect_done();
        do_offer(1);
        drain("R9 clip strobe");

        scen = 12;
        do_iack();
        do_start(1'b0, 10, 0, 10);
        do_offer(10);
        do_start(1'b0, 100, 0, -3);
        chk("R4 restart remain", int'(remain_o), 3);
        chk("R4 restart residual", int'(residual_o), -3);
        chk("R4 restart drops offer", int'(req_o), 0);
        chk("R4 restart stat", int'(stat_o), 0);
        drain("R4 restart no strobe");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule